// File: doc/BRIEF.md
# Taskfile Register-Write Sequencer

This block runs the command part of a 64-byte command parameter block that has already been copied into its local word buffer. The buffer is filled through a simple word-load port while the block is idle. The first 16 bytes of the block are the header. Their first word carries the control flags and the error field. The remaining bytes form a list of 16-bit entries. On a start pulse the sequencer walks this list in order. Within each 32-bit word the low half is taken before the high half. For each entry it issues one write on a parallel ATA-style device register bus, carrying a chip-select bit, a 3-bit register address and a data byte.

Flags in each entry let the sequencer skip the entry, hold the write until the device busy flag clears, or end the list. When the walk ends, the block writes any error bits back into the header word. It emits a one-cycle done pulse, and an interrupt pulse with it when the header enables one. It also reports whether a data-transfer descriptor chain should follow. A busy wait that lasts longer than a programmable limit aborts the command. A list that has no end marker is also stopped, and both cases are reported as errors.

Top module: `tfs_seq`

## Requirements
- R1: After reset the sequencer is idle: `seq_active`, `bus_wr`, `done`, `irq` and `err_flags` are all zero.
- R2: Entry k is taken from buffer word 4 + k/2, low half when k is even and high half when k is odd. Each executed entry gives exactly one `bus_wr` pulse. The pulse carries data = entry bits 7:0, `bus_addr` = bits 10:8 and `bus_cs1` = bit 12, and entries are executed in list order.
- R3: An entry with bit 13 set produces no bus write, and the walk continues with the next entry.
- R4: An entry with bit 14 set and bit 13 clear is not written while `dev_busy` is high. Its write is issued once `dev_busy` is seen low.
- R5: An entry with bit 15 set is the last entry processed, and any entries after it produce no write.
- R6: If none of the 24 entries has bit 15 set, the walk stops after the 24th entry. Error bit 3 of header word 0 (`err_flags` bit 0) is then set.
- R7: If the busy wait lasts more than `busy_limit` cycles, the command aborts and the waiting entry and all later entries are not written. Error bit 4 of header word 0 (`err_flags` bit 1) is then set.
- R8: Completion gives a `done` pulse of exactly one cycle. `irq` pulses with it only when header word 0 bit 19 is set.
- R9: After completion, `chain_go` equals header word 0 bit 18.
- R10: Error bits are ORed into header word 0 bits 7:3 at completion, and all other bits of that word are left unchanged. The word is read back on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load one buffer word (only acted on while idle) |
| ld_idx | input | 4 | Buffer word index to load |
| ld_data | input | 32 | Word to load |
| rd_idx | input | 4 | Buffer word index to read |
| rd_data | output | 32 | Buffer word at `rd_idx` |
| start | input | 1 | Begin walking the entry list |
| busy_limit | input | 16 | Cycle limit for a busy wait |
| dev_busy | input | 1 | Device busy flag |
| bus_wr | output | 1 | Register write strobe, one cycle per entry |
| bus_cs1 | output | 1 | Chip-select bit of the write |
| bus_addr | output | 3 | Register address of the write |
| bus_data | output | 8 | Data byte of the write |
| seq_active | output | 1 | Sequencer is walking or finishing |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt pulse |
| chain_go | output | 1 | Descriptor chain should follow |
| err_flags | output | 5 | Error bits of the last command (header bits 7:3) |

## Verification
The assertions assume that the buffer is loaded only while the sequencer is idle, and that `start` arrives only while it is idle. The bench loads all sixteen words and pulses `start` only after the previous `done`, so it stays within these conditions. They also assume that `dev_busy` is a plain level that the device may hold for any number of cycles. The bench raises it before a start, holds it across waiting entries, and either drops it within the limit or keeps it high past the limit to force the abort.

// File: rtl/tfs_pkg.sv
// Shared types and fixed bit positions for the taskfile sequencer.
// Assumes 32-bit buffer words and 16-bit list entries.
package tfs_pkg;
    localparam int WORD_W        = 32;
    localparam int ENT_W         = 16;
    localparam int HDR_CHAIN_BIT = 18;
    localparam int HDR_IEN_BIT   = 19;
    localparam int ERR_LO        = 3;
    localparam int ERR_W         = 5;
    localparam int ERR_NOEND     = 0;   // header bit 3
    localparam int ERR_TMO       = 1;   // header bit 4

    typedef struct packed {
        logic       last;
        logic       wnb;
        logic       skip;
        logic       cs1;
        logic [2:0] addr;
        logic [7:0] data;
    } entry_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_FIN} seq_state_t;
endpackage

// File: rtl/tfs_cpb_buf.sv
// Local copy of the command parameter block. It has a load port, two
// combinational read ports and an error write-back into word 0.
// Assumes the write-back and the load never target the same cycle
// (the top gates loads to idle).
module tfs_cpb_buf
    import tfs_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WIDX_W-1:0] ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              wb_en,
    input  logic [ERR_W-1:0]  wb_err,
    input  logic [WIDX_W-1:0] ra_idx,
    output logic [WORD_W-1:0] ra_data,
    input  logic [WIDX_W-1:0] rb_idx,
    output logic [WORD_W-1:0] rb_data,
    output logic [WORD_W-1:0] hdr
);
    logic [WORD_W-1:0] mem [WORDS];

    // Storage update: clear on reset, error write-back first, then loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wb_en) begin
            mem[0][ERR_LO +: ERR_W] <= mem[0][ERR_LO +: ERR_W] | wb_err;
        end else if (ld_en) begin
            mem[ld_idx] <= ld_data;
        end
    end

    // Read ports.
    always_comb begin
        ra_data = mem[ra_idx];
        rb_data = mem[rb_idx];
        hdr     = mem[0];
    end

    // R10: write-back leaves the bits above the error field alone.
    p_wb_keeps_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (mem[0][WORD_W-1:ERR_LO+ERR_W] == $past(mem[0][WORD_W-1:ERR_LO+ERR_W])));
endmodule

// File: rtl/tfs_entry_decode.sv
// Selects one 16-bit entry from a buffer word and splits it into fields.
// Assumes little-endian packing: the even entry sits in the low half.
module tfs_entry_decode
    import tfs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              hi_half,
    output entry_t            ent
);
    logic [ENT_W-1:0] raw;

    // Half select and field split.
    always_comb begin
        raw      = hi_half ? word[WORD_W-1:ENT_W] : word[ENT_W-1:0];
        ent.data = raw[7:0];
        ent.addr = raw[10:8];
        ent.cs1  = raw[12];
        ent.skip = raw[13];
        ent.wnb  = raw[14];
        ent.last = raw[15];
    end
endmodule

// File: rtl/tfs_busy_timer.sv
// Counts cycles spent in a busy wait and flags when the limit is reached.
// Assumes clr is held whenever the sequencer is not waiting.
module tfs_busy_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Wait counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en && !expired) cnt <= cnt + 1'b1;
    end

    // Limit compare.
    always_comb expired = (cnt >= limit);

    // R7: the limit can only be reached while counting a wait.
    p_expire_in_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(clr) && $rose(expired)) |-> $past(en));
endmodule

// File: rtl/tfs_seq_fsm.sv
// Walks the entry list: issues one registered bus write per executed entry,
// handles skip, busy wait, end marker, missing end and wait timeout.
// Assumes start arrives only while idle.
module tfs_seq_fsm
    import tfs_pkg::*;
#(
    parameter int ENTRIES = 24,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dev_busy,
    input  entry_t           ent,
    input  logic             tmo_expired,
    input  logic             hdr_chain,
    output logic [IDX_W-1:0] idx,
    output logic             in_wait,
    output logic             active,
    output logic             done,
    output logic             wb_en,
    output logic [ERR_W-1:0] wb_err,
    output logic             bus_wr,
    output logic             bus_cs1,
    output logic [2:0]       bus_addr,
    output logic [7:0]       bus_data,
    output logic             chain_go,
    output logic [ERR_W-1:0] err_flags
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    seq_state_t       state;
    logic [ERR_W-1:0] err_acc;
    logic             at_end;
    logic             no_end;

    // End-of-walk decisions for the current entry.
    always_comb begin
        at_end = ent.last || (idx == LAST_IDX);
        no_end = !ent.last && (idx == LAST_IDX);
    end

    // Main sequencing state, walk index, bus write register and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            err_acc   <= '0;
            bus_wr    <= 1'b0;
            bus_cs1   <= 1'b0;
            bus_addr  <= '0;
            bus_data  <= '0;
            chain_go  <= 1'b0;
            err_flags <= '0;
        end else begin
            bus_wr <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state   <= S_RUN;
                        idx     <= '0;
                        err_acc <= '0;
                    end
                end
                S_RUN: begin
                    if (!ent.skip && ent.wnb && dev_busy) begin
                        state <= S_WAIT;
                    end else begin
                        if (!ent.skip) begin
                            bus_wr   <= 1'b1;
                            bus_cs1  <= ent.cs1;
                            bus_addr <= ent.addr;
                            bus_data <= ent.data;
                        end
                        if (at_end) begin
                            state <= S_FIN;
                            if (no_end) err_acc[ERR_NOEND] <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    if (!dev_busy) begin
                        bus_wr   <= 1'b1;
                        bus_cs1  <= ent.cs1;
                        bus_addr <= ent.addr;
                        bus_data <= ent.data;
                        if (at_end) begin
                            state <= S_FIN;
                            if (no_end) err_acc[ERR_NOEND] <= 1'b1;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_RUN;
                        end
                    end else if (tmo_expired) begin
                        err_acc[ERR_TMO] <= 1'b1;
                        state            <= S_FIN;
                    end
                end
                default: begin
                    state     <= S_IDLE;
                    err_flags <= err_acc;
                    chain_go  <= hdr_chain;
                end
            endcase
        end
    end

    // Status decode.
    always_comb begin
        active  = (state != S_IDLE);
        in_wait = (state == S_WAIT);
        done    = (state == S_FIN);
        wb_en   = done;
        wb_err  = err_acc;
    end

    // R2: writes only follow a cycle spent walking.
    p_wr_from_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($past(state) == S_RUN || $past(state) == S_WAIT));
    // R4: no write leaves a wait while the device is busy.
    p_no_wr_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && dev_busy) |=> !bus_wr);
    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: the walk index never leaves the list.
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);
endmodule

// File: rtl/tfs_seq.sv
// Top of the taskfile register-write sequencer: buffer, entry decode,
// busy-wait timer and walk controller. Assumes loads and start only while idle.
module tfs_seq
    import tfs_pkg::*;
#(
    parameter int BLK_BYTES = 64,
    parameter int HDR_BYTES = 16,
    parameter int TMO_W     = 16,
    localparam int WORDS     = BLK_BYTES / 4,
    localparam int WIDX_W    = $clog2(WORDS),
    localparam int HDR_WORDS = HDR_BYTES / 4,
    localparam int ENTRIES   = (BLK_BYTES - HDR_BYTES) / 2,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WIDX_W-1:0] ld_idx,
    input  logic [31:0]       ld_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_data,
    input  logic              start,
    input  logic [TMO_W-1:0]  busy_limit,
    input  logic              dev_busy,
    output logic              bus_wr,
    output logic              bus_cs1,
    output logic [2:0]        bus_addr,
    output logic [7:0]        bus_data,
    output logic              seq_active,
    output logic              done,
    output logic              irq,
    output logic              chain_go,
    output logic [4:0]        err_flags
);
    logic [IDX_W-1:0]  idx;
    logic [WIDX_W-1:0] ent_widx;
    logic [WORD_W-1:0] ent_word;
    logic [WORD_W-1:0] hdr;
    entry_t            ent;
    logic              in_wait;
    logic              tmo_expired;
    logic              wb_en;
    logic [ERR_W-1:0]  wb_err;
    logic              ld_ok;

    // Entry address and gated load.
    always_comb begin
        ent_widx = WIDX_W'(HDR_WORDS) + WIDX_W'(idx >> 1);
        ld_ok    = ld_en && !seq_active;
        irq      = done && hdr[HDR_IEN_BIT];
    end

    tfs_cpb_buf #(.WORDS(WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_ok), .ld_idx(ld_idx), .ld_data(ld_data),
        .wb_en(wb_en), .wb_err(wb_err),
        .ra_idx(ent_widx), .ra_data(ent_word),
        .rb_idx(rd_idx), .rb_data(rd_data),
        .hdr(hdr)
    );

    tfs_entry_decode u_dec (
        .word(ent_word), .hi_half(idx[0]), .ent(ent)
    );

    tfs_busy_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(!in_wait), .en(in_wait),
        .limit(busy_limit), .expired(tmo_expired)
    );

    tfs_seq_fsm #(.ENTRIES(ENTRIES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .dev_busy(dev_busy), .ent(ent),
        .tmo_expired(tmo_expired), .hdr_chain(hdr[HDR_CHAIN_BIT]),
        .idx(idx), .in_wait(in_wait), .active(seq_active), .done(done),
        .wb_en(wb_en), .wb_err(wb_err),
        .bus_wr(bus_wr), .bus_cs1(bus_cs1), .bus_addr(bus_addr), .bus_data(bus_data),
        .chain_go(chain_go), .err_flags(err_flags)
    );

    // R8: the interrupt never appears without completion.
    p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> seq_active);
endmodule

// File: tb/tfs_seq_tb.sv
module tfs_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        start = 1'b0;
    logic [15:0] busy_limit = 16'd10;
    logic        dev_busy = 1'b0;
    logic        bus_wr, bus_cs1, seq_active, done, irq, chain_go;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_data;
    logic [4:0]  err_flags;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int wr_cnt = 0;
    logic done_seen = 0;
    logic irq_seen = 0;
    logic [7:0]  log_data [32];
    logic [2:0]  log_addr [32];
    logic        log_cs   [32];
    logic [31:0] blk [16];

    always #5 clk = ~clk;

    tfs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .start(start), .busy_limit(busy_limit),
        .dev_busy(dev_busy), .bus_wr(bus_wr), .bus_cs1(bus_cs1), .bus_addr(bus_addr),
        .bus_data(bus_data), .seq_active(seq_active), .done(done), .irq(irq),
        .chain_go(chain_go), .err_flags(err_flags)
    );

    // Bus monitor and completion capture, sampled mid-cycle.
    always @(negedge clk) begin
        cycles++;
        if (bus_wr && wr_cnt < 32) begin
            log_data[wr_cnt] = bus_data;
            log_addr[wr_cnt] = bus_addr;
            log_cs[wr_cnt]   = bus_cs1;
        end
        if (bus_wr) wr_cnt++;
        if (done) done_seen = 1;
        if (irq) irq_seen = 1;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [7:0] d, input logic [2:0] a, input logic cs,
                                       input logic ign, input logic wnb, input logic last);
        return {last, wnb, ign, cs, 1'b0, a, d};
    endfunction

    task automatic clear_blk(input logic [31:0] hdr);
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = hdr;
    endtask

    task automatic put(input int k, input logic [15:0] e);
        blk[4 + k/2][16*(k%2) +: 16] = e;
    endtask

    task automatic load_blk();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 4'(i); ld_data = blk[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic kick();
        wr_cnt = 0; done_seen = 0; irq_seen = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done_seen; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 active", 32'(seq_active), 0);
        check("R1 bus_wr", 32'(bus_wr), 0);
        check("R1 done", 32'(done), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 err", 32'(err_flags), 0);
    endtask

    task automatic t_basic();
        clear_blk(32'h02CC_0000);
        put(0, mk(8'hA5, 3'd1, 1, 0, 0, 0));
        put(1, mk(8'h3C, 3'd6, 0, 0, 0, 0));
        put(2, mk(8'h5A, 3'd7, 1, 0, 0, 1));
        put(3, mk(8'h77, 3'd2, 1, 0, 0, 0));
        load_blk(); kick(); wait_done();
        check("R5 write count", 32'(wr_cnt), 3);
        check("R2 data0", 32'(log_data[0]), 32'hA5);
        check("R2 addr0", 32'(log_addr[0]), 1);
        check("R2 cs0", 32'(log_cs[0]), 1);
        check("R2 data1 high half", 32'(log_data[1]), 32'h3C);
        check("R2 addr1", 32'(log_addr[1]), 6);
        check("R2 cs1", 32'(log_cs[1]), 0);
        check("R2 data2", 32'(log_data[2]), 32'h5A);
        check("R8 done", 32'(done_seen), 1);
        check("R8 irq enabled", 32'(irq_seen), 1);
        check("R9 chain set", 32'(chain_go), 1);
        check("R10 no error", 32'(err_flags), 0);
    endtask

    task automatic t_skip();
        clear_blk(32'h0);
        put(0, mk(8'h01, 3'd2, 1, 0, 0, 0));
        put(1, mk(8'h02, 3'd3, 0, 1, 1, 0));
        put(2, mk(8'h03, 3'd4, 0, 1, 0, 1));
        dev_busy = 1'b1;
        load_blk(); kick(); wait_done();
        dev_busy = 1'b0;
        check("R3 only one write", 32'(wr_cnt), 1);
        check("R3 written entry", 32'(log_data[0]), 32'h01);
        check("R8 done without irq", 32'(done_seen), 1);
        check("R8 irq disabled", 32'(irq_seen), 0);
        check("R9 chain clear", 32'(chain_go), 0);
        rd_idx = 4'd0; @(negedge clk);
        check("R10 word0 unchanged", rd_data, 32'h0);
    endtask

    task automatic t_wait();
        busy_limit = 16'd10;
        clear_blk(32'h0008_0000);
        put(0, mk(8'h11, 3'd5, 1, 0, 1, 1));
        dev_busy = 1'b1;
        load_blk(); kick();
        repeat (4) @(negedge clk);
        check("R4 held while busy", 32'(wr_cnt), 0);
        dev_busy = 1'b0;
        wait_done();
        check("R4 write after busy", 32'(wr_cnt), 1);
        check("R4 data", 32'(log_data[0]), 32'h11);
        check("R7 no timeout", 32'(err_flags), 0);
        check("R8 irq", 32'(irq_seen), 1);
    endtask

    task automatic t_timeout();
        busy_limit = 16'd4;
        clear_blk(32'h00C0_0000);
        put(0, mk(8'h22, 3'd0, 1, 0, 0, 0));
        put(1, mk(8'h33, 3'd1, 1, 0, 1, 0));
        put(2, mk(8'h44, 3'd0, 1, 0, 0, 1));
        dev_busy = 1'b1;
        load_blk(); kick(); wait_done();
        dev_busy = 1'b0;
        check("R7 writes before abort", 32'(wr_cnt), 1);
        check("R7 timeout flag", 32'(err_flags), 32'h2);
        rd_idx = 4'd0; @(negedge clk);
        check("R10 word0 timeout", rd_data, 32'h00C0_0010);
    endtask

    task automatic t_noend();
        busy_limit = 16'd10;
        clear_blk(32'h0000_0000);
        for (int k = 0; k < 24; k++) put(k, mk(8'(k), 3'(k), 1'(k), 0, 0, 0));
        load_blk(); kick(); wait_done();
        check("R6 all entries written", 32'(wr_cnt), 24);
        check("R6 last entry", 32'(log_data[23]), 23);
        check("R2 order entry 9", 32'(log_data[9]), 9);
        check("R6 missing end flag", 32'(err_flags), 32'h1);
        rd_idx = 4'd0; @(negedge clk);
        check("R10 word0 no end", rd_data, 32'h0000_0008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_skip();
        t_wait();
        t_timeout();
        t_noend();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule